// File: doc/BRIEF.md
# Far Return Segment Permission Checker

This block decides whether a protected-mode far return may proceed. It is given the selector being returned to, the pre-decoded fields of that selector's code descriptor, the current privilege level and the descriptor table limit. When the return lowers privilege it is also given the stack selector and its decoded descriptor. It returns a verdict: pass or fail, a fault class, the error code that goes with it, whether the return stays at the current level or moves to an outer one, and which of four data segment registers must be set to null.

Every rule is evaluated in parallel. A priority encoder then chooses the earliest failing rule in a fixed order, and that rule alone sets the fault class and the error code. Descriptor fetches and canonical address checks happen upstream, so every field arrives already decoded.

A request enters on a valid/ready handshake and its verdict leaves on a second valid/ready handshake, through one output register. The input is accepted when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the verdict holds steady and no new request is taken.

Top module: `frc_top`

## Requirements
- R1: A code selector whose bits [15:2] are all zero fails with fault class GP (`res_fault` = 1) and error code 0. This rule has the highest priority.
- R2: A code selector whose last descriptor byte ({sel[15:3],3'b111}) exceeds `tbl_limit` fails with GP. The error code is the selector with bits [1:0] cleared. When the last descriptor byte equals the limit, the selector passes this rule.
- R3: A descriptor that is not a code segment fails with GP and the selector's error code. So does a descriptor with both the L and D bits set while `long_mode` is 1. When `long_mode` is 0, L and D together are accepted.
- R4: A code selector RPL (bits [1:0]) below `cur_pl` fails with GP and the selector's error code.
- R5: A conforming code segment whose DPL is greater than the RPL fails with GP and the selector's error code. A non-conforming code segment whose DPL differs from the RPL also fails that way.
- R6: A code segment that is not present fails with fault class NP (`res_fault` = 2) and the selector's error code. This applies only when R1 to R5 all pass.
- R7: A passing verdict has `res_ok` = 1 and `res_fault` = 0 (none). Its `res_outer` is 1 exactly when the code RPL exceeds `cur_pl`. On any failure, `res_outer` is 0.
- R8: On an outer return, a stack selector whose bits [15:2] are zero fails with GP and error code 0. The exception is when `long_mode` = 1, the code L bit is set, the code RPL is not 3 and the stack RPL equals the code RPL: the null stack is then accepted and no other stack rule applies.
- R9: On an outer return with a non-null stack selector, the return fails with GP and the stack selector's error code (bits [1:0] cleared) in any of these cases: the stack descriptor lies beyond the limit, the stack RPL differs from the code RPL, the descriptor is not a writable data segment, or the stack DPL differs from the code RPL.
- R10: A stack segment that is not present fails with fault class SS (`res_fault` = 3) and the stack selector's error code. This applies only when R9 passes.
- R11: On a passing outer return, bit i of `res_null_mask` is 1 when `dseg_null[i]` is set. It is also 1 when the register's DPL (`dseg_dpl[2i+1:2i]`) is below the code RPL and `dseg_conf[i]` is 0. In every other case the mask is all zeros.
- R12: A verdict appears on `out_valid` in the cycle after its input handshake. It stays stable until `out_ready` takes it. `in_ready` equals `!out_valid || out_ready`. After reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| cur_pl | input | 2 | Current privilege level |
| long_mode | input | 1 | Long mode active |
| tbl_limit | input | 16 | Descriptor table limit in bytes |
| code_sel | input | 16 | Return code selector |
| code_is_code | input | 1 | Descriptor is a code segment |
| code_conf | input | 1 | Code segment is conforming |
| code_dpl | input | 2 | Code descriptor DPL |
| code_present | input | 1 | Code segment present |
| code_l | input | 1 | Code descriptor L bit |
| code_d | input | 1 | Code descriptor D bit |
| stk_sel | input | 16 | Return stack selector |
| stk_is_data | input | 1 | Stack descriptor is a data segment |
| stk_writable | input | 1 | Stack segment writable |
| stk_dpl | input | 2 | Stack descriptor DPL |
| stk_present | input | 1 | Stack segment present |
| dseg_null | input | 4 | Data segment register holds a null selector |
| dseg_dpl | input | 8 | DPL of each data segment register, two bits each |
| dseg_conf | input | 4 | Data segment register holds conforming code |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Verdict taken |
| res_ok | output | 1 | Return allowed |
| res_fault | output | 2 | Fault class: 0 none, 1 GP, 2 NP, 3 SS |
| res_err | output | 16 | Error code |
| res_outer | output | 1 | Return moves to an outer level |
| res_null_mask | output | 4 | Data segment registers to set to null |

## Verification
Each verdict is due exactly one cycle after its input handshake, and it must then hold for as long as `out_ready` stays low. The bench drives inputs on the falling edge and samples one time unit later. At that point it checks `out_valid` and `in_ready` against a behavioural handshake model on every clock. It compares the packed verdict against the head of a queue of expected results whenever the model predicts a drain. `out_ready` is thrown low at random, which covers the stalled and back-to-back cases. Directed vectors probe each rule, its boundary and the order between adjacent rules. Random vectors then mix all of them.

// File: rtl/frc_pkg.sv
package frc_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_NP   = 2'd2,
    FLT_SS   = 2'd3
  } flt_e;

  localparam int CODE_RULES = 8;
  localparam int STK_RULES  = 6;
  localparam int ALL_RULES  = CODE_RULES + STK_RULES;

  // rule slots, lowest index has highest priority
  localparam int RC_NULL   = 0;
  localparam int RC_LIMIT  = 1;
  localparam int RC_TYPE   = 2;
  localparam int RC_LD     = 3;
  localparam int RC_RPL    = 4;
  localparam int RC_CONF   = 5;
  localparam int RC_NCONF  = 6;
  localparam int RC_ABSENT = 7;
  localparam int RS_NULL   = 0;
  localparam int RS_LIMIT  = 1;
  localparam int RS_RPL    = 2;
  localparam int RS_TYPE   = 3;
  localparam int RS_DPL    = 4;
  localparam int RS_ABSENT = 5;
endpackage

// File: rtl/frc_prio.sv
module frc_prio #(
  parameter  int N  = 14,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/frc_code_chk.sv
module frc_code_chk
  import frc_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic [1:0]            cur_pl,
  input  logic                  long_mode,
  input  logic [SW-1:0]         sel,
  input  logic [SW-1:0]         lim,
  input  logic                  is_code,
  input  logic                  conf,
  input  logic [1:0]            dpl,
  input  logic                  present,
  input  logic                  l_bit,
  input  logic                  d_bit,
  output logic [CODE_RULES-1:0] fail,
  output logic                  outer
);
  logic [1:0]    rpl;
  logic [SW-1:0] last_byte;

  assign rpl       = sel[1:0];
  assign last_byte = {sel[SW-1:3], 3'b111};

  always_comb begin
    fail            = '0;
    fail[RC_NULL]   = (sel[SW-1:2] == '0);
    fail[RC_LIMIT]  = (last_byte > lim);
    fail[RC_TYPE]   = !is_code;
    fail[RC_LD]     = long_mode && l_bit && d_bit;
    fail[RC_RPL]    = (rpl < cur_pl);
    fail[RC_CONF]   = conf && (dpl > rpl);
    fail[RC_NCONF]  = !conf && (dpl != rpl);
    fail[RC_ABSENT] = !present;
  end

  assign outer = (rpl > cur_pl);
endmodule

// File: rtl/frc_stack_chk.sv
module frc_stack_chk
  import frc_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic                 long_mode,
  input  logic                 code_l,
  input  logic [1:0]           tgt_rpl,
  input  logic [SW-1:0]        sel,
  input  logic [SW-1:0]        lim,
  input  logic                 is_data,
  input  logic                 writable,
  input  logic [1:0]           dpl,
  input  logic                 present,
  output logic [STK_RULES-1:0] fail
);
  logic          is_null;
  logic          null_ok;
  logic          live;
  logic [SW-1:0] last_byte;

  assign is_null   = (sel[SW-1:2] == '0);
  assign null_ok   = long_mode && code_l && (tgt_rpl != 2'd3) && (sel[1:0] == tgt_rpl);
  assign live      = !is_null;
  assign last_byte = {sel[SW-1:3], 3'b111};

  always_comb begin
    fail            = '0;
    fail[RS_NULL]   = is_null && !null_ok;
    fail[RS_LIMIT]  = live && (last_byte > lim);
    fail[RS_RPL]    = live && (sel[1:0] != tgt_rpl);
    fail[RS_TYPE]   = live && !(is_data && writable);
    fail[RS_DPL]    = live && (dpl != tgt_rpl);
    fail[RS_ABSENT] = live && !present;
  end
endmodule

// File: rtl/frc_null_mask.sv
module frc_null_mask #(
  parameter int NSEG = 4
) (
  input  logic [1:0]        new_pl,
  input  logic [NSEG-1:0]   seg_null,
  input  logic [2*NSEG-1:0] seg_dpl,
  input  logic [NSEG-1:0]   seg_conf,
  output logic [NSEG-1:0]   mask
);
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [1:0] d;
    assign d       = seg_dpl[2*g +: 2];
    assign mask[g] = seg_null[g] || ((d < new_pl) && !seg_conf[g]);
  end
endmodule

// File: rtl/frc_top.sv
module frc_top
  import frc_pkg::*;
#(
  parameter int SW   = 16,
  parameter int NSEG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        cur_pl,
  input  logic              long_mode,
  input  logic [SW-1:0]     tbl_limit,
  input  logic [SW-1:0]     code_sel,
  input  logic              code_is_code,
  input  logic              code_conf,
  input  logic [1:0]        code_dpl,
  input  logic              code_present,
  input  logic              code_l,
  input  logic              code_d,
  input  logic [SW-1:0]     stk_sel,
  input  logic              stk_is_data,
  input  logic              stk_writable,
  input  logic [1:0]        stk_dpl,
  input  logic              stk_present,
  input  logic [NSEG-1:0]   dseg_null,
  input  logic [2*NSEG-1:0] dseg_dpl,
  input  logic [NSEG-1:0]   dseg_conf,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              res_ok,
  output logic [1:0]        res_fault,
  output logic [SW-1:0]     res_err,
  output logic              res_outer,
  output logic [NSEG-1:0]   res_null_mask
);
  localparam int IW = $clog2(ALL_RULES);

  logic [CODE_RULES-1:0] cfail;
  logic [STK_RULES-1:0]  sfail;
  logic [ALL_RULES-1:0]  rules;
  logic                  to_outer;
  logic                  hit;
  logic [IW-1:0]         hit_idx;
  logic [NSEG-1:0]       mask_c;
  logic [SW-1:0]         code_ec;
  logic [SW-1:0]         stk_ec;
  flt_e                  flt_c;
  logic [SW-1:0]         err_c;
  logic                  accept;

  frc_code_chk #(.SW(SW)) u_code (
    .cur_pl   (cur_pl),
    .long_mode(long_mode),
    .sel      (code_sel),
    .lim      (tbl_limit),
    .is_code  (code_is_code),
    .conf     (code_conf),
    .dpl      (code_dpl),
    .present  (code_present),
    .l_bit    (code_l),
    .d_bit    (code_d),
    .fail     (cfail),
    .outer    (to_outer)
  );

  frc_stack_chk #(.SW(SW)) u_stack (
    .long_mode(long_mode),
    .code_l   (code_l),
    .tgt_rpl  (code_sel[1:0]),
    .sel      (stk_sel),
    .lim      (tbl_limit),
    .is_data  (stk_is_data),
    .writable (stk_writable),
    .dpl      (stk_dpl),
    .present  (stk_present),
    .fail     (sfail)
  );

  frc_null_mask #(.NSEG(NSEG)) u_mask (
    .new_pl  (code_sel[1:0]),
    .seg_null(dseg_null),
    .seg_dpl (dseg_dpl),
    .seg_conf(dseg_conf),
    .mask    (mask_c)
  );

  // stack rules only count when privilege drops
  assign rules = {sfail & {STK_RULES{to_outer}}, cfail};

  frc_prio #(.N(ALL_RULES)) u_prio (
    .req(rules),
    .any(hit),
    .idx(hit_idx)
  );

  assign code_ec = {code_sel[SW-1:2], 2'b00};
  assign stk_ec  = {stk_sel[SW-1:2], 2'b00};

  always_comb begin
    flt_c = FLT_NONE;
    err_c = '0;
    if (hit) begin
      if (int'(hit_idx) < CODE_RULES) begin
        unique case (int'(hit_idx))
          RC_NULL:   begin flt_c = FLT_GP; err_c = '0;      end
          RC_ABSENT: begin flt_c = FLT_NP; err_c = code_ec; end
          default:   begin flt_c = FLT_GP; err_c = code_ec; end
        endcase
      end else begin
        unique case (int'(hit_idx) - CODE_RULES)
          RS_NULL:   begin flt_c = FLT_GP; err_c = '0;     end
          RS_ABSENT: begin flt_c = FLT_SS; err_c = stk_ec; end
          default:   begin flt_c = FLT_GP; err_c = stk_ec; end
        endcase
      end
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      res_ok        <= 1'b0;
      res_fault     <= FLT_NONE;
      res_err       <= '0;
      res_outer     <= 1'b0;
      res_null_mask <= '0;
    end else if (accept) begin
      out_valid     <= 1'b1;
      res_ok        <= !hit;
      res_fault     <= flt_c;
      res_err       <= err_c;
      res_outer     <= !hit && to_outer;
      res_null_mask <= (!hit && to_outer) ? mask_c : '0;
    end else if (out_ready) begin
      out_valid     <= 1'b0;
    end
  end

  // R12: a stalled verdict does not move
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_err) && $stable(res_fault) && $stable(res_ok));

  // R7: pass flag agrees with the fault class
  p_ok_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (res_ok == (res_fault == FLT_NONE)));

  // R11: nulling only on a passing outer return
  p_mask_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (res_null_mask != '0) |-> res_ok && res_outer);

  // R1: null code selector gives GP with code zero
  p_null_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (code_sel[SW-1:2] == '0) |=> out_valid && res_fault == FLT_GP && res_err == '0);

  // R4: returning to a more privileged level never passes
  p_rpl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (code_sel[1:0] < cur_pl) |=> out_valid && !res_ok);
endmodule

// File: tb/frc_top_test.sv
module frc_top_test;
  localparam int SW   = 16;
  localparam int NSEG = 4;

  typedef struct {
    logic [1:0]  cpl;
    logic        lm;
    logic [15:0] lim;
    logic [15:0] csel;
    logic        c_code, c_conf, c_p, c_l, c_d;
    logic [1:0]  c_dpl;
    logic [15:0] ssel;
    logic        s_data, s_wr, s_p;
    logic [1:0]  s_dpl;
    logic [3:0]  dn;
    logic [7:0]  dd;
    logic [3:0]  dc;
  } vec_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [1:0]  cur_pl, code_dpl, stk_dpl, res_fault;
  logic        long_mode, code_is_code, code_conf, code_present, code_l, code_d;
  logic        stk_is_data, stk_writable, stk_present, res_ok, res_outer;
  logic [15:0] tbl_limit, code_sel, stk_sel, res_err;
  logic [3:0]  dseg_null, dseg_conf, res_null_mask;
  logic [7:0]  dseg_dpl;

  frc_top #(.SW(SW), .NSEG(NSEG)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .cur_pl(cur_pl), .long_mode(long_mode), .tbl_limit(tbl_limit),
    .code_sel(code_sel), .code_is_code(code_is_code), .code_conf(code_conf),
    .code_dpl(code_dpl), .code_present(code_present), .code_l(code_l), .code_d(code_d),
    .stk_sel(stk_sel), .stk_is_data(stk_is_data), .stk_writable(stk_writable),
    .stk_dpl(stk_dpl), .stk_present(stk_present),
    .dseg_null(dseg_null), .dseg_dpl(dseg_dpl), .dseg_conf(dseg_conf),
    .out_valid(out_valid), .out_ready(out_ready),
    .res_ok(res_ok), .res_fault(res_fault), .res_err(res_err),
    .res_outer(res_outer), .res_null_mask(res_null_mask)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  vec_t        vq[$];
  string       tq[$];
  logic [23:0] eq[$];
  string       etq[$];

  task automatic chk(bit ok, string tag, string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] pk(bit ok, logic [1:0] f, logic [15:0] e, bit o, logic [3:0] m);
    return {ok, f, e, o, m};
  endfunction

  function automatic logic [3:0] nmask(vec_t v);
    logic [3:0] m = '0;
    for (int i = 0; i < 4; i++)
      if (v.dn[i] || (int'(v.dd[2*i +: 2]) < int'(v.csel[1:0]) && !v.dc[i])) m[i] = 1'b1;
    return m;
  endfunction

  function automatic bit beyond(logic [15:0] s, logic [15:0] l);
    return (int'(s >> 3) * 8 + 7) > int'(l);
  endfunction

  // behavioural verdict, rules in priority order
  function automatic logic [23:0] model(vec_t v);
    int rpl = int'(v.csel[1:0]);
    int cpl = int'(v.cpl);
    logic [15:0] ce = v.csel & 16'hFFFC;
    logic [15:0] se = v.ssel & 16'hFFFC;
    if ((v.csel >> 2) == 0)                return pk(0, 2'd1, 16'h0, 0, 4'h0);
    if (beyond(v.csel, v.lim))             return pk(0, 2'd1, ce, 0, 4'h0);
    if (!v.c_code)                         return pk(0, 2'd1, ce, 0, 4'h0);
    if (v.lm && v.c_l && v.c_d)            return pk(0, 2'd1, ce, 0, 4'h0);
    if (rpl < cpl)                         return pk(0, 2'd1, ce, 0, 4'h0);
    if (v.c_conf && int'(v.c_dpl) > rpl)   return pk(0, 2'd1, ce, 0, 4'h0);
    if (!v.c_conf && int'(v.c_dpl) != rpl) return pk(0, 2'd1, ce, 0, 4'h0);
    if (!v.c_p)                            return pk(0, 2'd2, ce, 0, 4'h0);
    if (rpl == cpl)                        return pk(1, 2'd0, 16'h0, 0, 4'h0);
    if ((v.ssel >> 2) == 0) begin
      if (v.lm && v.c_l && rpl != 3 && int'(v.ssel[1:0]) == rpl)
        return pk(1, 2'd0, 16'h0, 1, nmask(v));
      return pk(0, 2'd1, 16'h0, 0, 4'h0);
    end
    if (beyond(v.ssel, v.lim))             return pk(0, 2'd1, se, 0, 4'h0);
    if (int'(v.ssel[1:0]) != rpl)          return pk(0, 2'd1, se, 0, 4'h0);
    if (!(v.s_data && v.s_wr))             return pk(0, 2'd1, se, 0, 4'h0);
    if (int'(v.s_dpl) != rpl)              return pk(0, 2'd1, se, 0, 4'h0);
    if (!v.s_p)                            return pk(0, 2'd3, se, 0, 4'h0);
    return pk(1, 2'd0, 16'h0, 1, nmask(v));
  endfunction

  function automatic vec_t base();
    vec_t v;
    v.cpl = 2'd0; v.lm = 1'b0; v.lim = 16'h00FF;
    v.csel = 16'h0008; v.c_code = 1; v.c_conf = 0; v.c_dpl = 2'd0;
    v.c_p = 1; v.c_l = 0; v.c_d = 0;
    v.ssel = 16'h0010; v.s_data = 1; v.s_wr = 1; v.s_dpl = 2'd0; v.s_p = 1;
    v.dn = 4'h0; v.dd = 8'hFF; v.dc = 4'h0;
    return v;
  endfunction

  // outer-level good case: code RPL 3 from CPL 0
  function automatic vec_t outer_base();
    vec_t v = base();
    v.csel = 16'h000B; v.c_dpl = 2'd3;
    v.ssel = 16'h0013; v.s_dpl = 2'd3;
    return v;
  endfunction

  task automatic add(vec_t v, string tag);
    vq.push_back(v);
    tq.push_back(tag);
  endtask

  task automatic apply(vec_t v);
    cur_pl = v.cpl; long_mode = v.lm; tbl_limit = v.lim;
    code_sel = v.csel; code_is_code = v.c_code; code_conf = v.c_conf;
    code_dpl = v.c_dpl; code_present = v.c_p; code_l = v.c_l; code_d = v.c_d;
    stk_sel = v.ssel; stk_is_data = v.s_data; stk_writable = v.s_wr;
    stk_dpl = v.s_dpl; stk_present = v.s_p;
    dseg_null = v.dn; dseg_dpl = v.dd; dseg_conf = v.dc;
  endtask

  task automatic build();
    vec_t v;
    v = base(); add(v, "R7");
    v = base(); v.csel = 16'h0003; v.c_dpl = 2'd3; add(v, "R1");
    v = base(); v.csel = 16'h0100; add(v, "R2");
    v = base(); v.csel = 16'h00F8; add(v, "R2");
    v = base(); v.csel = 16'h00F8; v.lim = 16'h00FE; add(v, "R2");
    v = base(); v.c_code = 0; add(v, "R3");
    v = base(); v.lm = 1; v.c_l = 1; v.c_d = 1; add(v, "R3");
    v = base(); v.c_l = 1; v.c_d = 1; add(v, "R3");
    v = base(); v.cpl = 2'd2; v.csel = 16'h0009; v.c_dpl = 2'd1; add(v, "R4");
    v = base(); v.cpl = 2'd1; v.csel = 16'h0009; v.c_conf = 1; v.c_dpl = 2'd2; add(v, "R5");
    v = base(); v.cpl = 2'd1; v.csel = 16'h0009; v.c_conf = 1; v.c_dpl = 2'd0; add(v, "R5");
    v = base(); v.cpl = 2'd1; v.csel = 16'h0009; v.c_dpl = 2'd0; add(v, "R5");
    v = base(); v.c_p = 0; add(v, "R6");
    v = base(); v.c_p = 0; v.c_code = 0; add(v, "R6");
    v = outer_base(); add(v, "R7");
    v = outer_base(); v.ssel = 16'h0003; add(v, "R8");
    v = outer_base(); v.ssel = 16'h0003; v.lm = 1; v.c_l = 1; add(v, "R8");
    v = outer_base(); v.csel = 16'h000A; v.c_dpl = 2'd2; v.ssel = 16'h0002;
    v.lm = 1; v.c_l = 1; add(v, "R8");
    v = outer_base(); v.csel = 16'h000A; v.c_dpl = 2'd2; v.ssel = 16'h0001;
    v.lm = 1; v.c_l = 1; add(v, "R8");
    v = outer_base(); v.ssel = 16'h0103; add(v, "R9");
    v = outer_base(); v.ssel = 16'h0012; add(v, "R9");
    v = outer_base(); v.s_wr = 0; add(v, "R9");
    v = outer_base(); v.s_data = 0; add(v, "R9");
    v = outer_base(); v.s_dpl = 2'd2; add(v, "R9");
    v = outer_base(); v.s_p = 0; add(v, "R10");
    v = outer_base(); v.s_p = 0; v.s_wr = 0; add(v, "R10");
    v = outer_base(); v.dn = 4'b0001; v.dd = 8'b10_00_01_11; v.dc = 4'b0100; add(v, "R11");
    v = outer_base(); v.csel = 16'h000A; v.c_dpl = 2'd2; v.ssel = 16'h0012;
    v.s_dpl = 2'd2; v.dd = 8'b11_10_01_00; v.dc = 4'b0010; add(v, "R11");
    v = base(); v.dn = 4'hF; v.dd = 8'h00; add(v, "R11");
    for (int i = 0; i < 400; i++) begin
      v.cpl = 2'($urandom); v.lm = 1'($urandom); v.lim = 16'h00FF;
      v.csel = 16'($urandom % 300); v.c_code = ($urandom % 8) != 0;
      v.c_conf = 1'($urandom); v.c_dpl = 2'($urandom); v.c_p = ($urandom % 8) != 0;
      v.c_l = 1'($urandom); v.c_d = 1'($urandom);
      v.ssel = 16'($urandom % 300); v.s_data = ($urandom % 6) != 0;
      v.s_wr = ($urandom % 6) != 0; v.s_dpl = 2'($urandom); v.s_p = ($urandom % 6) != 0;
      v.dn = 4'($urandom); v.dd = 8'($urandom); v.dc = 4'($urandom);
      add(v, "R12");
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    vec_t        curv;
    string       ctag;
    logic [23:0] act, exp;
    string       etag;
    bit          mv, pend, acc;
    int          idx;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    apply(base());
    build();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R12", "reset out_valid", 24'(out_valid), 24'h0);
    chk(in_ready == 1'b1, "R12", "reset in_ready", 24'(in_ready), 24'h1);
    rst_n = 1'b1;
    mv = 0; pend = 0; idx = 0;
    while (idx < vq.size() || pend || eq.size() > 0) begin
      @(negedge clk);
      if (!pend) begin
        if (idx < vq.size()) begin
          curv = vq[idx]; ctag = tq[idx]; idx++;
          apply(curv); in_valid = 1'b1; pend = 1;
        end else begin
          in_valid = 1'b0;
        end
      end
      out_ready = ($urandom % 4) != 0;
      #1;
      chk(out_valid == mv, "R12", "out_valid", 24'(out_valid), 24'(mv));
      chk(in_ready == (!mv || out_ready), "R12", "in_ready", 24'(in_ready), 24'(!mv || out_ready));
      if (mv && out_ready && eq.size() > 0) begin
        exp  = eq.pop_front();
        etag = etq.pop_front();
        act  = {res_ok, res_fault, res_err, res_outer, res_null_mask};
        chk(act == exp, etag, "verdict", act, exp);
      end
      acc = in_valid && (!mv || out_ready);
      if (acc) begin
        eq.push_back(model(curv));
        etq.push_back(ctag);
        pend = 0;
      end
      mv = acc || (mv && !out_ready);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule